// File: doc/BRIEF.md
# Vectored Priority Interrupt Merger

This block folds thirteen level-sensitive interrupt lines, numbered 1 to 13, into a single request toward the processor. The request is a 3-bit level (zero means no request) and an 8-bit vector. Every line has its own 8-bit control byte. Bits 4:0 of that byte form a combined level-and-priority value, and bits 4:2 of it are the level reported to the processor. Bit 7 selects autovectoring. A 16-bit mask blocks lines, and a 16-bit pending image shows the present state of the lines.

Software programs the block through a byte-wide register port with a combinational read path. Among the unmasked lines that are high, the line with the greatest 5-bit value wins. The request is suppressed when that value is below a minimum. The vector then comes from one of two places. With autovectoring it is computed from the level. Without it, the line picks a programmable vector byte: the watchdog line and the two serial lines have their own bytes, and every other line falls back to a fixed default. Both outputs are registered.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A line whose mask bit is 1 never contributes to the request. Mask bit n (n = 1..13) belongs to line n, and the set of lines taking part is the input lines AND NOT the mask.
- R2: The winner is the taking-part line with the strictly greatest control bits 4:0. When two lines tie, the lower-numbered line wins.
- R3: When the winning 5-bit value is below 4, or no line takes part, both irq_level and irq_vector are 0.
- R4: When a request is made, irq_level equals bits 4:2 of the winner's control byte.
- R5: When bit 7 of the winner's control byte is 1, irq_vector equals 24 plus irq_level.
- R6: When bit 7 of the winner's control byte is 0, the vector is chosen by line number:
  - line 8 uses the watchdog vector byte;
  - line 12 uses serial vector byte A;
  - line 13 uses serial vector byte B;
  - every other line gets 0x0F.
- R7: After reset, the control bytes for lines 1..13 read 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x1C, 0x80, 0x80, 0x80, 0x00, 0x00. The mask reads 0x3FFE, the watchdog vector 0x0F, both serial vectors 0x00, and both outputs are 0.
- R8: The pending image has bit n equal to line n as sampled at the last clock edge. Bits 0, 14 and 15 read 0.
- R9: irq_level and irq_vector are registered. They change at the first clock edge after a change of lines, mask or control bytes, and not before.
- R10: The register map is as follows:
  - the control byte for line n sits at address n-1 (0x00..0x0C);
  - the mask low byte (bits 7:0) is at 0x10 and its high byte at 0x11;
  - the pending image, read-only, is at 0x12 (low byte) and 0x13 (high byte);
  - the watchdog vector is at 0x14, serial vector A at 0x15 and serial vector B at 0x16.
  
  Writes to the pending image have no effect, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 13 | Interrupt lines, bit n = line n (indices 13:1) |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe for bus_wdata |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq_level | output | 3 | Requested level, 0 = none |
| irq_vector | output | 8 | Vector for the request |

## Verification
Several properties are checked on every cycle:
- the chosen line is one that actually takes part;
- a cycle with no taking-part line gives zero outputs one edge later;
- a zero level always comes with a zero vector;
- an autovectored winner produces 24 plus its level on the next edge.

Only the bench scenarios can show the rest:
- the reset contents of every register;
- the tie-break toward the lower line number;
- the per-line vector choice;
- that writes to the pending image change nothing;
- that the outputs hold their old values until the edge after an input change.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_SRC = 13;
    localparam int ID_W    = $clog2(NUM_SRC + 1);
    localparam int MASK_W  = 16;

    typedef struct packed {
        logic [NUM_SRC:1][7:0] ctrl;
        logic [MASK_W-1:0]     mask;
        logic [MASK_W-1:0]     pend;
        logic [7:0]            wdog_vec;
        logic [7:0]            ser0_vec;
        logic [7:0]            ser1_vec;
        logic [2:0]            level;
        logic [7:0]            vector;
    } irqc_state_t;

    // Reset contents of the control byte for one line.
    function automatic logic [7:0] ctrl_reset(input int src);
        if (src <= 7)       return 8'(src * 4);
        else if (src == 8)  return 8'h1C;
        else if (src <= 11) return 8'h80;
        else                return 8'h00;
    endfunction

    function automatic irqc_state_t state_reset();
        irqc_state_t s;
        s = '0;
        for (int i = 1; i <= NUM_SRC; i++) s.ctrl[i] = ctrl_reset(i);
        s.mask     = 16'h3FFE;
        s.wdog_vec = 8'h0F;
        return s;
    endfunction

endpackage

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int N        = 13,
    parameter int IDW      = 4,
    parameter int MIN_PRIO = 4
) (
    input  logic [N:1]      active,
    input  logic [N:1][7:0] ctrl,
    output logic            hit,
    output logic [IDW-1:0]  win_id,
    output logic [7:0]      win_ctrl
);
    logic [4:0] best;

    always_comb begin
        best     = '0;
        win_id   = '0;
        win_ctrl = '0;
        // Strictly greater: the lowest line keeps a tie.
        for (int i = 1; i <= N; i++) begin
            if (active[i] && (ctrl[i][4:0] > best)) begin
                best     = ctrl[i][4:0];
                win_id   = IDW'(i);
                win_ctrl = ctrl[i];
            end
        end
        hit = (best >= 5'(MIN_PRIO));
    end
endmodule

// File: rtl/irqc_vecsel.sv
module irqc_vecsel #(
    parameter int         IDW       = 4,
    parameter int         AUTO_BASE = 24,
    parameter logic [7:0] DFLT_VEC  = 8'h0F,
    parameter int         WDOG_SRC  = 8,
    parameter int         SER0_SRC  = 12,
    parameter int         SER1_SRC  = 13
) (
    input  logic           hit,
    input  logic [IDW-1:0] win_id,
    input  logic [7:0]     win_ctrl,
    input  logic [7:0]     wdog_vec,
    input  logic [7:0]     ser0_vec,
    input  logic [7:0]     ser1_vec,
    output logic [2:0]     level,
    output logic [7:0]     vector
);
    always_comb begin
        level  = hit ? win_ctrl[4:2] : 3'd0;
        vector = 8'h00;
        if (hit) begin
            if (win_ctrl[7])                     vector = 8'(AUTO_BASE) + 8'(level);
            else if (win_id == IDW'(WDOG_SRC))   vector = wdog_vec;
            else if (win_id == IDW'(SER0_SRC))   vector = ser0_vec;
            else if (win_id == IDW'(SER1_SRC))   vector = ser1_vec;
            else                                 vector = DFLT_VEC;
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irqc_pkg::*;
#(
    parameter int         MIN_PRIO  = 4,
    parameter int         AUTO_BASE = 24,
    parameter logic [7:0] DFLT_VEC  = 8'h0F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC:1]   irq_in,
    input  logic [7:0]         bus_addr,
    input  logic               bus_we,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    output logic [2:0]         irq_level,
    output logic [7:0]         irq_vector
);
    localparam logic [7:0] A_MASK_LO = 8'h10;
    localparam logic [7:0] A_MASK_HI = 8'h11;
    localparam logic [7:0] A_PEND_LO = 8'h12;
    localparam logic [7:0] A_PEND_HI = 8'h13;
    localparam logic [7:0] A_WDOG    = 8'h14;
    localparam logic [7:0] A_SER0    = 8'h15;
    localparam logic [7:0] A_SER1    = 8'h16;
    localparam int         PAD_W     = MASK_W - NUM_SRC - 1;

    irqc_state_t s_d, s_q;

    logic [NUM_SRC:1] active;
    logic             hit;
    logic [ID_W-1:0]  win_id;
    logic [7:0]       win_ctrl;
    logic [2:0]       level_nx;
    logic [7:0]       vector_nx;

    assign active = irq_in & ~s_q.mask[NUM_SRC:1];

    irqc_arbiter #(.N(NUM_SRC), .IDW(ID_W), .MIN_PRIO(MIN_PRIO)) u_arb (
        .active   (active),
        .ctrl     (s_q.ctrl),
        .hit      (hit),
        .win_id   (win_id),
        .win_ctrl (win_ctrl)
    );

    irqc_vecsel #(.IDW(ID_W), .AUTO_BASE(AUTO_BASE), .DFLT_VEC(DFLT_VEC)) u_vec (
        .hit      (hit),
        .win_id   (win_id),
        .win_ctrl (win_ctrl),
        .wdog_vec (s_q.wdog_vec),
        .ser0_vec (s_q.ser0_vec),
        .ser1_vec (s_q.ser1_vec),
        .level    (level_nx),
        .vector   (vector_nx)
    );

    always_comb begin
        s_d        = s_q;
        s_d.pend   = {{PAD_W{1'b0}}, irq_in, 1'b0};
        s_d.level  = level_nx;
        s_d.vector = vector_nx;
        if (bus_we) begin
            for (int i = 1; i <= NUM_SRC; i++)
                if (bus_addr == 8'(i - 1)) s_d.ctrl[i] = bus_wdata;
            case (bus_addr)
                A_MASK_LO: s_d.mask[7:0]  = bus_wdata;
                A_MASK_HI: s_d.mask[15:8] = bus_wdata;
                A_WDOG:    s_d.wdog_vec   = bus_wdata;
                A_SER0:    s_d.ser0_vec   = bus_wdata;
                A_SER1:    s_d.ser1_vec   = bus_wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= state_reset();
        else        s_q <= s_d;
    end

    always_comb begin
        bus_rdata = 8'h00;
        for (int i = 1; i <= NUM_SRC; i++)
            if (bus_addr == 8'(i - 1)) bus_rdata = s_q.ctrl[i];
        case (bus_addr)
            A_MASK_LO: bus_rdata = s_q.mask[7:0];
            A_MASK_HI: bus_rdata = s_q.mask[15:8];
            A_PEND_LO: bus_rdata = s_q.pend[7:0];
            A_PEND_HI: bus_rdata = s_q.pend[15:8];
            A_WDOG:    bus_rdata = s_q.wdog_vec;
            A_SER0:    bus_rdata = s_q.ser0_vec;
            A_SER1:    bus_rdata = s_q.ser1_vec;
            default:   ;
        endcase
    end

    assign irq_level  = s_q.level;
    assign irq_vector = s_q.vector;

    // R2
    win_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (win_id >= ID_W'(1) && win_id <= ID_W'(NUM_SRC) && active[win_id]));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |=> (irq_level == 3'd0 && irq_vector == 8'h00));

    // R3
    zero_level_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == 3'd0) |-> (irq_vector == 8'h00));

    // R5
    autovec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && win_ctrl[7]) |=> (irq_vector == 8'(AUTO_BASE) + 8'(irq_level)));
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N = 13;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N:1]   irq_in = '0;
    logic [7:0]   bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [7:0]   bus_wdata = '0;
    logic [7:0]   bus_rdata;
    logic [2:0]   irq_level;
    logic [7:0]   irq_vector;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0]  sh_ctrl [1:N];
    logic [15:0] sh_mask;
    logic [7:0]  sh_wdog, sh_ser0, sh_ser1;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_level(irq_level), .irq_vector(irq_vector)
    );

    // Expected {level, vector} from the shadow registers.
    function automatic logic [10:0] model(input logic [N:1] lines);
        int best = 0; int win = 0;
        logic [2:0] lv; logic [7:0] vc;
        for (int i = 1; i <= N; i++)
            if (lines[i] && !sh_mask[i] && int'(sh_ctrl[i][4:0]) > best) begin
                best = int'(sh_ctrl[i][4:0]); win = i;
            end
        if (best < 4) return 11'd0;
        lv = sh_ctrl[win][4:2];
        if (sh_ctrl[win][7]) vc = 8'(24 + int'(lv));
        else if (win == 8)   vc = sh_wdog;
        else if (win == 12)  vc = sh_ser0;
        else if (win == 13)  vc = sh_ser1;
        else                 vc = 8'h0F;
        return {lv, vc};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        if (a <= 8'h0C) sh_ctrl[int'(a) + 1] = d;
        else if (a == 8'h10) sh_mask[7:0] = d;
        else if (a == 8'h11) sh_mask[15:8] = d;
        else if (a == 8'h14) sh_wdog = d;
        else if (a == 8'h15) sh_ser0 = d;
        else if (a == 8'h16) sh_ser1 = d;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        bus_addr = a; #1;
        check(req, 32'(bus_rdata), 32'(exp));
    endtask

    // Drive lines, step one edge, compare outputs.
    task automatic apply(input string req, input logic [N:1] lines);
        logic [10:0] e;
        irq_in = lines;
        @(negedge clk);
        e = model(lines);
        check(req, {21'd0, irq_level, irq_vector}, {21'd0, e});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [10:0] old_e;
        void'($urandom(32'd12345));
        for (int i = 1; i <= N; i++)
            sh_ctrl[i] = (i <= 7) ? 8'(i*4) : (i == 8) ? 8'h1C : (i <= 11) ? 8'h80 : 8'h00;
        sh_mask = 16'h3FFE; sh_wdog = 8'h0F; sh_ser0 = 8'h00; sh_ser1 = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 reset contents
        for (int i = 1; i <= N; i++) rd_chk("R7 ctrl", 8'(i - 1), sh_ctrl[i]);
        rd_chk("R7 mask lo", 8'h10, 8'hFE);
        rd_chk("R7 mask hi", 8'h11, 8'h3F);
        rd_chk("R7 wdog", 8'h14, 8'h0F);
        rd_chk("R7 ser0", 8'h15, 8'h00);
        rd_chk("R7 ser1", 8'h16, 8'h00);
        check("R7 outputs", {21'd0, irq_level, irq_vector}, 32'd0);
        rd_chk("R10 unmapped", 8'h30, 8'h00);

        // R1 all masked by default
        apply("R1 masked", '1);
        wr(8'h10, 8'h00); wr(8'h11, 8'h00);

        // R2 tie: lines 7 and 8 both 0x1C, line 7 wins -> default vector
        apply("R2 tie", 13'b0000011000000);
        check("R6 default", 32'(irq_vector), 32'h0F);

        // R6 line 8 alone uses watchdog vector
        wr(8'h14, 8'h5A);
        apply("R6 wdog", 13'b0000010000000);
        check("R6 wdog vec", 32'(irq_vector), 32'h5A);

        // R3 below threshold
        wr(8'h00, 8'h03);
        apply("R3 threshold", 13'b0000000000001);
        check("R3 level", 32'(irq_level), 32'd0);

        // R5 autovector, R4 level
        wr(8'h08, 8'h9D);
        apply("R5 auto", 13'b0000100000000);
        check("R4 level", 32'(irq_level), 32'd7);
        check("R5 vec", 32'(irq_vector), 32'd31);

        // R6 serial lines
        wr(8'h0B, 8'h08); wr(8'h0C, 8'h0C); wr(8'h15, 8'hA1); wr(8'h16, 8'hB2);
        apply("R6 ser0", 13'b0100000000000);
        apply("R6 ser1", 13'b1100000000000);

        // R9 latency: outputs hold until the next edge
        old_e = model(13'b1100000000000);
        irq_in = 13'b0000000000100;
        #(CLK_PERIOD/4);
        check("R9 hold", {21'd0, irq_level, irq_vector}, {21'd0, old_e});
        @(negedge clk);
        check("R9 update", {21'd0, irq_level, irq_vector}, {21'd0, model(13'b0000000000100)});

        // R8 pending image; R10 writes to pending ignored
        irq_in = 13'b1010000000101;
        @(negedge clk);
        rd_chk("R8 pend lo", 8'h12, 8'b00001010);
        rd_chk("R8 pend hi", 8'h13, 8'b00101000);
        wr(8'h12, 8'hFF);
        rd_chk("R10 pend ro", 8'h12, 8'b00001010);
        apply("R10 pend write", 13'b1010000000101);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            int r = int'($urandom_range(0, 9));
            if (r < 3)       wr(8'($urandom_range(0, 12)), 8'($urandom));
            else if (r == 3) wr(8'($urandom_range(8'h10, 8'h11)), 8'($urandom));
            else if (r == 4) wr(8'($urandom_range(8'h14, 8'h16)), 8'($urandom));
            apply("R2 random", 13'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule